// File: doc/BRIEF.md
# Sequence-Keyed Watchdog Timer

This block is a supervision timer that software has to service at regular intervals. It stays idle until two independent mode-select inputs are both high. Once armed, it counts enable ticks. Software keeps it alive by writing two key bits in a fixed two-step order: first the pattern 1/0, then the pattern 0/1. Completing that pair within the window clears the count and starts a fresh window. A single write of any kind does not restart it.

If a full window of ticks passes without a completed key pair, the block does two things. It sets a sticky overflow interrupt flag, which stays set until a clear input is asserted. It also emits a reset request that is one clock cycle wide. The count then starts again from zero, and the block stays armed. The window length is a parameter given in ticks. The default of 128000 ticks gives a 128 ms window with a 1 MHz tick.

Top module: `seq_watchdog`

## Requirements
- R1: While rst_n is low, ovf_irq and wd_rst_pulse are 0, and the key tracker and tick count are cleared to zero.
- R2: The block is armed only while mode_a and mode_b are both 1. When it is not armed, the count and the key tracker are held at zero, and the block produces no wd_rst_pulse and sets no ovf_irq.
- R3: While armed, the TICKS-th tick counted since arming, since the last restart or since the last expiry is an expiry. wd_rst_pulse is high in the clock cycle after the edge that samples that tick.
- R4: A key write is wr_en=1 with {key_hi,key_lo}. Step 1 is key_hi=1, key_lo=0. Step 2 is key_hi=0, key_lo=1. Step 2 written directly after step 1 restarts the count at zero.
- R5: Any write other than the expected next step returns the tracker to idle. A repeated step 1 keeps the tracker at step 1. A step 2 without a pending step 1 has no effect on the count.
- R6: wd_rst_pulse lasts exactly one clock cycle. After an expiry the count restarts from zero while the block stays armed, so the next expiry comes TICKS ticks later.
- R7: ovf_irq is set on expiry and stays set until ovf_clr is sampled high. A clear in the same cycle as an expiry wins, so ovf_irq reads 0 afterwards.
- R8: A completed step 2 in the same cycle as the tick that would complete the window restarts the count, and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per time unit |
| mode_a | input | 1 | First mode-select bit |
| mode_b | input | 1 | Second mode-select bit |
| wr_en | input | 1 | Key register write strobe |
| key_hi | input | 1 | First key bit of the write |
| key_lo | input | 1 | Second key bit of the write |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_irq | output | 1 | Sticky watchdog overflow flag |
| wd_rst_pulse | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with TICKS set to 8, so a single run can reach many expiries, back-to-back windows and restarts. With this short window the bench can service the timer on the last tick before expiry, where the service must win (R8). It can also let the block expire in the same cycle as a clear, where the clear must win (R7). Random traffic uses keys biased towards the valid pair and mode bits that change now and then. This drives the tracker through every order of writes while the block is armed and while it is not.

// File: rtl/seq_watchdog.sv
module seq_watchdog #(
  parameter int TICKS = 128000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mode_a,
  input  logic mode_b,
  input  logic wr_en,
  input  logic key_hi,
  input  logic key_lo,
  input  logic ovf_clr,
  output logic ovf_irq,
  output logic wd_rst_pulse
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          step1_seen;

  wire armed   = mode_a & mode_b;
  wire is_step1 = wr_en & key_hi & ~key_lo;
  wire is_step2 = wr_en & ~key_hi & key_lo;
  wire service = armed & step1_seen & is_step2;
  wire expire  = armed & ~service & tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step1_seen <= 1'b0;
    end else if (!armed) begin
      step1_seen <= 1'b0;
    end else if (wr_en) begin
      step1_seen <= is_step1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!armed || service || expire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_rst_pulse <= 1'b0;
      ovf_irq      <= 1'b0;
    end else begin
      wd_rst_pulse <= expire;
      if (ovf_clr)     ovf_irq <= 1'b0;
      else if (expire) ovf_irq <= 1'b1;
    end
  end
endmodule

// File: rtl/seq_watchdog_chk.sv
module seq_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_a,
  input logic mode_b,
  input logic ovf_clr,
  input logic ovf_irq,
  input logic wd_rst_pulse
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!ovf_irq && !wd_rst_pulse));

  p_disarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_a && mode_b) |=> !wd_rst_pulse);

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_pulse |=> !wd_rst_pulse);

  p_pulse_sets_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_pulse) |-> (ovf_irq || $past(ovf_clr)));

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf_irq);

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !ovf_clr) |=> ovf_irq);
endmodule

bind seq_watchdog seq_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
  .ovf_clr(ovf_clr), .ovf_irq(ovf_irq), .wd_rst_pulse(wd_rst_pulse)
);

// File: tb/tb_seq_watchdog.sv
`timescale 1ns/1ps
module tb_seq_watchdog;
  localparam int TICKS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, mode_a = 1'b0, mode_b = 1'b0;
  logic wr_en = 1'b0, key_hi = 1'b0, key_lo = 1'b0, ovf_clr = 1'b0;
  logic ovf_irq, wd_rst_pulse;

  int total = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_stage = 0, m_irq = 0, m_pulse = 0;

  always #2 clk = ~clk;

  seq_watchdog #(.TICKS(TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_a(mode_a), .mode_b(mode_b),
    .wr_en(wr_en), .key_hi(key_hi), .key_lo(key_lo), .ovf_clr(ovf_clr),
    .ovf_irq(ovf_irq), .wd_rst_pulse(wd_rst_pulse)
  );

  function automatic bit expiry_due(bit armed, bit svc, bit tk, int cnt);
    return armed && !svc && tk && (cnt == TICKS - 1);
  endfunction

  function automatic bit key_service(bit armed, bit stage, bit we, bit hi, bit lo);
    return armed && stage && we && !hi && lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_stage = 0; m_irq = 0; m_pulse = 0;
    end else begin
      bit armed, svc, ex;
      armed = mode_a && mode_b;
      svc = key_service(armed, m_stage, wr_en, key_hi, key_lo);
      ex = expiry_due(armed, svc, tick, m_cnt);
      if (!armed) m_stage = 0;
      else if (wr_en) m_stage = key_hi && !key_lo;
      if (!armed || svc || ex) m_cnt = 0;
      else if (tick) m_cnt = m_cnt + 1;
      m_pulse = ex;
      if (ovf_clr) m_irq = 0;
      else if (ex) m_irq = 1;
    end
  end

  task automatic check(string tag);
    total++;
    if (ovf_irq !== m_irq || wd_rst_pulse !== m_pulse) begin
      fails++;
      $display("FAIL %s: irq=%b pulse=%b expected irq=%b pulse=%b",
               tag, ovf_irq, wd_rst_pulse, m_irq, m_pulse);
    end
  endtask

  task automatic expect_bits(string tag, bit irq_e, bit pulse_e);
    total++;
    if (ovf_irq !== irq_e || wd_rst_pulse !== pulse_e) begin
      fails++;
      $display("FAIL %s: irq=%b pulse=%b expected irq=%b pulse=%b",
               tag, ovf_irq, wd_rst_pulse, irq_e, pulse_e);
    end
  endtask

  task automatic step(bit a, bit b, bit tk, bit we, bit hi, bit lo, bit clr, string tag);
    mode_a = a; mode_b = b; tick = tk; wr_en = we; key_hi = hi; key_lo = lo; ovf_clr = clr;
    @(negedge clk);
    check(tag);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    expect_bits("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(0,0,0,0,0,0,0,"R1 after reset");

    // R2: ticks without arming never expire
    for (int i = 0; i < 3*TICKS; i++) step(1,0,1,0,0,0,0,"R2 half armed");
    expect_bits("R2 no pulse", 1'b0, 1'b0);

    // R3: exact window
    for (int i = 0; i < TICKS-1; i++) step(1,1,1,0,0,0,0,"R3 counting");
    expect_bits("R3 before expiry", 1'b0, 1'b0);
    step(1,1,1,0,0,0,0,"R3 final tick");
    expect_bits("R3 expiry", 1'b1, 1'b1);
    // R6: single cycle, restart
    step(1,1,0,0,0,0,0,"R6 pulse ends");
    expect_bits("R6 one cycle", 1'b1, 1'b0);
    for (int i = 0; i < TICKS; i++) step(1,1,1,0,0,0,0,"R6 next window");
    expect_bits("R6 second expiry", 1'b1, 1'b1);

    // R7: sticky and clear
    step(1,1,0,0,0,0,0,"R7 sticky");
    step(1,1,0,0,0,0,1,"R7 clear");
    expect_bits("R7 cleared", 1'b0, 1'b0);

    // R4/R8: service on the final tick
    for (int i = 0; i < TICKS-1; i++) step(1,1,1,0,0,0,0,"R8 approach");
    step(1,1,0,1,1,0,0,"R4 step1");
    step(1,1,1,1,0,1,0,"R8 step2 with last tick");
    expect_bits("R8 no expiry", 1'b0, 1'b0);
    for (int i = 0; i < TICKS-1; i++) step(1,1,1,0,0,0,0,"R4 fresh window");
    expect_bits("R4 restarted", 1'b0, 1'b0);
    step(1,1,1,0,0,0,0,"R4 expiry after restart");
    expect_bits("R4 expiry", 1'b1, 1'b1);

    // R5: lone step2 ignored, repeated step1, wrong write
    for (int i = 0; i < TICKS-1; i++) step(1,1,1,0,0,0,0,"R5 approach");
    step(1,1,0,1,0,1,0,"R5 lone step2");
    step(1,1,1,0,0,0,0,"R5 expiry despite step2");
    expect_bits("R5 lone step2 ignored", 1'b1, 1'b1);
    step(1,1,0,1,1,0,1,"R5 step1");
    step(1,1,0,1,1,0,0,"R5 step1 again");
    step(1,1,0,1,0,1,0,"R5 step2 after repeat");
    step(1,1,0,1,1,0,0,"R5 step1");
    step(1,1,0,1,1,1,0,"R5 wrong write");
    step(1,1,0,1,0,1,0,"R5 step2 after wrong");

    // R7: clear beats simultaneous expiry
    for (int i = 0; i < TICKS-1; i++) step(1,1,1,0,0,0,0,"R7 approach");
    step(1,1,1,0,0,0,1,"R7 clear with expiry");
    expect_bits("R7 clear wins", 1'b0, 1'b1);
    step(1,1,0,0,0,0,1,"R7 clear");

    // R2: disarm mid-window holds counter at zero
    for (int i = 0; i < TICKS-2; i++) step(1,1,1,0,0,0,0,"R2 partial");
    step(0,1,1,0,0,0,0,"R2 disarm");
    for (int i = 0; i < TICKS-1; i++) step(1,1,1,0,0,0,0,"R2 rearmed");
    expect_bits("R2 count held at zero", 1'b0, 1'b0);
    step(1,1,1,0,0,0,0,"R2 full window after rearm");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit a, b, tk, we, hi, lo, clr;
      int r;
      a = ($urandom_range(0, 19) != 0);
      b = ($urandom_range(0, 19) != 0);
      tk = $urandom_range(0, 1);
      we = ($urandom_range(0, 5) == 0);
      r = $urandom_range(0, 7);
      hi = (r < 3) || (r == 6);
      lo = (r >= 3 && r < 6) || (r == 6);
      clr = ($urandom_range(0, 15) == 0);
      step(a, b, tk, we, hi, lo, clr, "R3 R4 R5 R6 R7 random");
    end

    summary();
  end
endmodule